// File: doc/BRIEF.md
# DRAM Power-Up Wake Sequencer

This block sits on the controller side of an asynchronous-strobe DRAM port. It brings the memory from power-up to a usable state. After reset it holds every strobe inactive for a settling interval. The interval is computed at elaboration from the system clock frequency and the required start-up time, and it is rounded up to whole clock cycles.

After the interval it runs a train of dummy refresh cycles on the row strobe, column strobe, write-enable and address outputs. The train is never shorter than eight cycles. The `refresh_kind` input chooses the kind of refresh for the whole train:

- Row-address-only refresh presents a row address and pulls only the row strobe low.
- CAS-before-RAS refresh drops the column strobe one clock ahead of the row strobe.

Only after the final precharge does the block raise `ready`. It passes the memory-port request through only while `ready` is high.

The refresh kind and the programmed cycle count are captured once, when the settling interval ends. Write-enable stays high throughout, so a CAS-before-RAS cycle can never be taken as a special-mode entry. Reset at any moment aborts the sequence and starts it again from the settling interval.

Top module: `dram_wake_seq`

## Requirements
- R1: While reset is held, `ready` and `req_ok` are 0, `ras_n`, `cas_n` and `we_n` are 1 and `addr` is 0.
- R2: After reset is released, `ras_n` and `cas_n` both stay high for DELAY = ceil(STARTUP_US*CLK_KHZ/1000) clock cycles. The first `ras_n` fall is seen in cycle DELAY+2, counting the first cycle after release as cycle 1.
- R3: The number of row-strobe pulses before `ready` equals the larger of `wake_count` and MIN_WAKE (default 8).
- R4: With `refresh_kind`=0 (row-address-only), `cas_n` stays high for the whole sequence. At the fall of the k-th row-strobe pulse (k from 1), `addr` equals k-1.
- R5: With `refresh_kind`=1 (CAS-before-RAS), `cas_n` is already low in the cycle before every `ras_n` fall. It stays low while `ras_n` is low, and `addr` is 0 at each fall.
- R6: Each `ras_n` low pulse lasts exactly RAS_LOW_CYC cycles. Between two pulses, `ras_n` is high for exactly PRE_CYC+1 cycles.
- R7: `we_n` is 1 in every cycle.
- R8: `ready` rises exactly PRE_CYC cycles after the last `ras_n` rise. It then stays high with both strobes inactive until reset.
- R9: `req_ok` equals `req_in` AND `ready` in every cycle.
- R10: `refresh_kind` and `wake_count` are sampled only when the settling interval ends. Changes after that do not alter the pulse count or the refresh kind.
- R11: Asserting reset mid-sequence drops `ready` and the strobes at once. After release, the full sequence of R2 and R3 runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, restarts the sequence |
| refresh_kind | input | 1 | 0 = row-address-only refresh, 1 = CAS-before-RAS refresh |
| wake_count | input | CNT_W | Requested number of wake-up cycles (floored at MIN_WAKE) |
| req_in | input | 1 | Memory-port request from the client |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| addr | output | ROW_W | Row address for row-address-only refresh |
| ready | output | 1 | Initialization complete |
| req_ok | output | 1 | Request passed to the memory port |

## Verification
The hardest conditions to reach from the ports are those of R10 and R11, because both need an input change in a particular phase of a sequence that lasts thousands of cycles.

- For R10, the stimulus waits for the first observed row-strobe fall, which proves the capture has already happened. It then flips `refresh_kind` and raises `wake_count`, and the checks confirm the original kind and count still govern the train.
- For R11, the bench counts pulses and asserts reset at the fourth one. It then measures the restarted settling interval and train from the new release.

// File: rtl/dws_pkg.sv
package dws_pkg;

    typedef enum logic [2:0] {
        ST_SETTLE,
        ST_LEAD,
        ST_ACTIVE,
        ST_PRECH,
        ST_READY
    } dws_state_e;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/dws_settle_timer.sv
module dws_settle_timer #(
    parameter int unsigned DELAY_CYC = 20000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int unsigned CW = $clog2(DELAY_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!tmr_q.done) begin
            tmr_d.cnt  = tmr_q.cnt + 1'b1;
            tmr_d.done = (tmr_q.cnt == CW'(DELAY_CYC - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign done = tmr_q.done;
endmodule

// File: rtl/dws_row_walker.sv
module dws_row_walker #(
    parameter int unsigned ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [ROW_W-1:0] row
);
    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (clear)     row_d = '0;
        else if (step) row_d = row_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row = row_q;
endmodule

// File: rtl/dws_count_clamp.sv
module dws_count_clamp #(
    parameter int unsigned CNT_W   = 5,
    parameter int unsigned MIN_VAL = 8
) (
    input  logic [CNT_W-1:0] raw,
    output logic [CNT_W-1:0] eff
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_VAL);

    always_comb begin
        eff = (raw < FLOOR) ? FLOOR : raw;
    end
endmodule

// File: rtl/dram_wake_seq.sv
module dram_wake_seq
    import dws_pkg::*;
#(
    parameter int unsigned CLK_KHZ     = 100_000,
    parameter int unsigned STARTUP_US  = 200,
    parameter int unsigned MIN_WAKE    = 8,
    parameter int unsigned CNT_W       = 5,
    parameter int unsigned ROW_W       = 11,
    parameter int unsigned RAS_LOW_CYC = 4,
    parameter int unsigned PRE_CYC     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refresh_kind,
    input  logic [CNT_W-1:0] wake_count,
    input  logic             req_in,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] addr,
    output logic             ready,
    output logic             req_ok
);
    localparam int unsigned DELAY_CYC = ceil_div(STARTUP_US * CLK_KHZ, 1000);
    localparam int unsigned PH_MAX    = (RAS_LOW_CYC > PRE_CYC) ? RAS_LOW_CYC : PRE_CYC;
    localparam int unsigned PH_W      = $clog2(PH_MAX + 1);

    typedef struct packed {
        dws_state_e       st;
        logic [PH_W-1:0]  ph;
        logic [CNT_W-1:0] done;
        logic [CNT_W-1:0] target;
        logic             cbr;
        logic             ras_n;
        logic             cas_n;
        logic [ROW_W-1:0] addr;
        logic             ready;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st:     ST_SETTLE,
        ph:     '0,
        done:   '0,
        target: '0,
        cbr:    1'b0,
        ras_n:  1'b1,
        cas_n:  1'b1,
        addr:   '0,
        ready:  1'b0
    };

    seq_t seq_d, seq_q;

    logic             settle_done;
    logic [CNT_W-1:0] eff_count;
    logic [ROW_W-1:0] row;
    logic             row_step;
    logic             row_clear;

    dws_settle_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (settle_done)
    );

    dws_count_clamp #(.CNT_W(CNT_W), .MIN_VAL(MIN_WAKE)) u_clamp (
        .raw (wake_count),
        .eff (eff_count)
    );

    dws_row_walker #(.ROW_W(ROW_W)) u_rows (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (row_clear),
        .step  (row_step),
        .row   (row)
    );

    assign row_clear = (seq_q.st == ST_SETTLE);

    always_comb begin
        seq_d    = seq_q;
        row_step = 1'b0;
        case (seq_q.st)
            ST_SETTLE: begin
                if (settle_done) begin
                    seq_d.st     = ST_LEAD;
                    seq_d.cbr    = refresh_kind;
                    seq_d.target = eff_count;
                    seq_d.done   = '0;
                    seq_d.cas_n  = ~refresh_kind;
                    seq_d.addr   = refresh_kind ? '0 : row;
                end
            end
            ST_LEAD: begin
                seq_d.st    = ST_ACTIVE;
                seq_d.ras_n = 1'b0;
                seq_d.ph    = PH_W'(RAS_LOW_CYC - 1);
            end
            ST_ACTIVE: begin
                if (seq_q.ph == '0) begin
                    seq_d.st    = ST_PRECH;
                    seq_d.ras_n = 1'b1;
                    seq_d.cas_n = 1'b1;
                    seq_d.ph    = PH_W'(PRE_CYC - 1);
                    seq_d.done  = seq_q.done + 1'b1;
                    row_step    = 1'b1;
                end else begin
                    seq_d.ph = seq_q.ph - 1'b1;
                end
            end
            ST_PRECH: begin
                if (seq_q.ph == '0) begin
                    if (seq_q.done == seq_q.target) begin
                        seq_d.st    = ST_READY;
                        seq_d.ready = 1'b1;
                        seq_d.addr  = '0;
                    end else begin
                        seq_d.st    = ST_LEAD;
                        seq_d.cas_n = ~seq_q.cbr;
                        seq_d.addr  = seq_q.cbr ? '0 : row;
                    end
                end else begin
                    seq_d.ph = seq_q.ph - 1'b1;
                end
            end
            ST_READY: begin
                seq_d.ras_n = 1'b1;
                seq_d.cas_n = 1'b1;
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign ras_n  = seq_q.ras_n;
    assign cas_n  = seq_q.cas_n;
    assign we_n   = 1'b1;
    assign addr   = seq_q.addr;
    assign ready  = seq_q.ready;
    assign req_ok = req_in & seq_q.ready;
endmodule

// File: rtl/dws_checker.sv
module dws_checker #(
    parameter int unsigned DELAY_CYC   = 20000,
    parameter int unsigned RAS_LOW_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic ready
);
    localparam int unsigned CYC_W = $clog2(DELAY_CYC + 3);
    localparam int unsigned LOW_W = $clog2(RAS_LOW_CYC + 2);

    logic [CYC_W-1:0] cyc_q;
    logic [LOW_W-1:0] low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q     <= '0;
            low_run_q <= '0;
        end else begin
            if (cyc_q != CYC_W'(DELAY_CYC + 1)) cyc_q <= cyc_q + 1'b1;
            if (!ras_n) begin
                if (low_run_q != LOW_W'(RAS_LOW_CYC + 1)) low_run_q <= low_run_q + 1'b1;
            end else begin
                low_run_q <= '0;
            end
        end
    end

    // R2: strobes quiet through the whole settling interval
    p_quiet_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q <= CYC_W'(DELAY_CYC)) |-> (ras_n && cas_n));

    // R5: column strobe leads the row strobe when both are low
    p_cas_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> ($past(cas_n) == 1'b0));

    // R5: column strobe does not rise before the row strobe
    p_cas_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !cas_n) |=> (!cas_n || ras_n));

    // R6: every row-strobe pulse has the programmed width
    p_ras_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_run_q == LOW_W'(RAS_LOW_CYC)));

    // R8: ready is sticky until reset
    p_ready_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R8: strobes idle once ready
    p_idle_when_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ras_n && cas_n));
endmodule

bind dram_wake_seq dws_checker #(
    .DELAY_CYC   (DELAY_CYC),
    .RAS_LOW_CYC (RAS_LOW_CYC)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .ready (ready)
);

// File: tb/dram_wake_seq_tb_top.sv
`timescale 1ns/1ps
module dram_wake_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_KHZ    = 10_001;
    localparam int STARTUP_US = 200;
    localparam int MIN_WAKE   = 8;
    localparam int CNT_W      = 5;
    localparam int ROW_W      = 11;
    localparam int RAS_LOW    = 3;
    localparam int PRE        = 2;
    localparam int DELAY      = (STARTUP_US * CLK_KHZ + 999) / 1000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             refresh_kind = 1'b0;
    logic [CNT_W-1:0] wake_count = '0;
    logic             req_in = 1'b1;
    logic             ras_n, cas_n, we_n, ready, req_ok;
    logic [ROW_W-1:0] addr;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // monitor state
    bit exp_cbr = 1'b0;
    int n, pulses, low_len, high_len, last_rise, first_cas, first_ras, ready_n;
    int bad_we, bad_req, bad_cas, bad_addr, bad_width, bad_gap, bad_rdy;
    bit prev_ras, prev_cas;

    dram_wake_seq #(
        .CLK_KHZ(CLK_KHZ), .STARTUP_US(STARTUP_US), .MIN_WAKE(MIN_WAKE),
        .CNT_W(CNT_W), .ROW_W(ROW_W), .RAS_LOW_CYC(RAS_LOW), .PRE_CYC(PRE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .refresh_kind(refresh_kind),
        .wake_count(wake_count), .req_in(req_in), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .ready(ready), .req_ok(req_ok)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            n = 0; pulses = 0; low_len = 0; high_len = 0; last_rise = -1;
            first_cas = -1; first_ras = -1; ready_n = -1;
            bad_we = 0; bad_req = 0; bad_cas = 0; bad_addr = 0;
            bad_width = 0; bad_gap = 0; bad_rdy = 0;
            prev_ras = 1'b1; prev_cas = 1'b1;
        end else begin
            n = n + 1;
            if (we_n !== 1'b1) bad_we = bad_we + 1;
            if (req_ok !== (req_in & ready)) bad_req = bad_req + 1;
            if (!cas_n && first_cas < 0) first_cas = n;
            if (!exp_cbr && !cas_n) bad_cas = bad_cas + 1;
            if (exp_cbr && !ras_n && cas_n) bad_cas = bad_cas + 1;
            if (!ras_n && prev_ras) begin
                pulses = pulses + 1;
                if (first_ras < 0) first_ras = n;
                if (exp_cbr) begin
                    if (prev_cas !== 1'b0) bad_cas = bad_cas + 1;
                    if (addr !== '0) bad_addr = bad_addr + 1;
                end else if (addr !== ROW_W'(pulses - 1)) begin
                    bad_addr = bad_addr + 1;
                end
                if (pulses > 1 && high_len != PRE + 1) bad_gap = bad_gap + 1;
                high_len = 0;
            end
            if (ras_n && !prev_ras) begin
                if (low_len != RAS_LOW) bad_width = bad_width + 1;
                low_len = 0;
                last_rise = n;
            end
            if (!ras_n) low_len = low_len + 1;
            else        high_len = high_len + 1;
            if (ready && ready_n < 0) begin
                ready_n = n;
                if (n - last_rise != PRE) bad_rdy = bad_rdy + 1;
            end
            if (!ready && ready_n >= 0) bad_rdy = bad_rdy + 1;
            if (ready && (!ras_n || !cas_n)) bad_rdy = bad_rdy + 1;
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start_seq(input bit kind, input int count);
        refresh_kind = kind;
        wake_count   = CNT_W'(count);
        exp_cbr      = kind;
        @(negedge clk); #1 rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk); #1 rst_n = 1'b1;
    endtask

    task automatic wait_ready(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (ready) begin
                ok = 1'b1;
                break;
            end
        end
        #2;
    endtask

    task automatic check_train(input string tag, input int exp_pulses);
        chk(pulses == exp_pulses, {tag, " R3 pulse count"}, pulses, exp_pulses);
        chk(first_ras == DELAY + 2, {tag, " R2 first row strobe"}, first_ras, DELAY + 2);
        chk(bad_cas == 0, {tag, exp_cbr ? " R5 column strobe order" : " R4 column strobe idle"}, bad_cas, 0);
        chk(bad_addr == 0, {tag, exp_cbr ? " R5 address zero" : " R4 row walk"}, bad_addr, 0);
        chk(bad_width == 0 && bad_gap == 0, {tag, " R6 pulse and gap widths"}, bad_width + bad_gap, 0);
        chk(bad_we == 0, {tag, " R7 write enable high"}, bad_we, 0);
        chk(bad_rdy == 0, {tag, " R8 ready timing"}, bad_rdy, 0);
        chk(bad_req == 0, {tag, " R9 request gating"}, bad_req, 0);
    endtask

    task automatic t_reset_state();
        @(negedge clk); #1 rst_n = 1'b0; req_in = 1'b1;
        @(negedge clk);
        chk(ready == 1'b0 && req_ok == 1'b0, "R1 ready and req_ok low", {ready, req_ok}, 0);
        chk(ras_n && cas_n && we_n, "R1 strobes high", {ras_n, cas_n, we_n}, 7);
        chk(addr == '0, "R1 address zero", int'(addr), 0);
    endtask

    task automatic t_row_only();
        bit ok;
        start_seq(1'b0, 10);
        wait_ready(ok);
        chk(ok, "R8 ready reached row-only", ok, 1);
        chk(first_cas < 0, "R4 no column strobe", first_cas, -1);
        check_train("row-only", 10);
        repeat (20) @(negedge clk);
        #2;
        chk(ready && pulses == 10, "R8 stays ready and idle", pulses, 10);
    endtask

    task automatic t_cbr_clamp();
        bit ok;
        start_seq(1'b1, 3);
        wait_ready(ok);
        chk(ok, "R8 ready reached cas-first", ok, 1);
        chk(first_cas == DELAY + 1, "R2 R5 first column strobe", first_cas, DELAY + 1);
        check_train("cas-first clamp", MIN_WAKE);
    endtask

    task automatic t_zero_and_max();
        bit ok;
        start_seq(1'b1, 0);
        wait_ready(ok);
        check_train("count zero", MIN_WAKE);
        start_seq(1'b0, 31);
        wait_ready(ok);
        check_train("count max", 31);
    endtask

    task automatic t_late_change();
        bit ok;
        start_seq(1'b0, 9);
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (!ras_n) break;
        end
        #1 refresh_kind = 1'b1; wake_count = CNT_W'(20);
        wait_ready(ok);
        chk(first_cas < 0, "R10 kind change ignored", first_cas, -1);
        check_train("R10 late change", 9);
    endtask

    task automatic t_mid_reset();
        bit ok;
        start_seq(1'b1, 12);
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            #1;
            if (pulses == 4) break;
        end
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk(!ready && ras_n && cas_n, "R11 reset drops outputs", {ready, ras_n, cas_n}, 3);
        @(negedge clk); #1 rst_n = 1'b1;
        wait_ready(ok);
        chk(ok, "R11 ready after restart", ok, 1);
        check_train("R11 restart", 12);
    endtask

    initial begin
        t_reset_state();
        t_row_only();
        t_cbr_clamp();
        t_zero_and_max();
        t_late_change();
        t_mid_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule